// File: doc/BRIEF.md
# Processor Interrupt Level Selector

This block decides which external interrupt level, if any, is presented to a processor core. It keeps a vector of sixteen request lines, and peripherals raise or lower these lines one at a time through a small event port. It merges that vector with a software-interrupt word, in which two timer-match bits are redirected to level 14. It then searches downward from level 15 for the highest pending level that lies above the core's current interrupt level. The selected level is turned into a trap type by OR-ing it onto an external-interrupt base of 0x40. A hard-interrupt request flag goes with that trap type.

A request is withheld while the core runs at a nonzero trap level and the trap type active there is greater than the candidate. A new request is issued only when the candidate differs from the one already presented. When nothing is pending, any standing request is withdrawn. When interrupts are globally disabled, the request state is left as it is. Raising a request line also wakes the core from a halt state, which the core enters through a separate strobe.

Top module: `pil_select_top`

## Requirements
- R1: After a synchronous active-low reset, `hard_req` is 0, `sel_tt` is 0, `halted` is 0 and every request line is clear.
- R2: The pending vector is the request lines OR-ed with `softint`, where `softint` bit k stands for level k, except that bits 0 (tick match) and 15 (system-tick match) take no part in that OR.
- R3: When `softint` bit 0 or bit 15 is set, level 14 is pending.
- R4: With `int_en` high, the candidate is the highest pending level strictly above `cur_pil`, and the trap type presented is 0x40 OR the level (for example, level 9 gives 0x049). When the candidate differs from `sel_tt`, it is loaded into `sel_tt` and `hard_req` is set.
- R5: When no pending level lies above `cur_pil`, `hard_req` and `sel_tt` keep their values.
- R6: When the pending vector is all zero and `hard_req` is 1, both `hard_req` and `sel_tt` return to 0. This happens whatever the value of `int_en`.
- R7: When `trap_lvl` is nonzero and `active_tt` is greater than the candidate trap type, the outputs are left unchanged. When `active_tt` equals the candidate, or when `trap_lvl` is 0, the candidate is taken.
- R8: With `int_en` low and something pending, `hard_req` and `sel_tt` keep their values.
- R9: A cycle with `line_evt` high writes `line_val` into the request line numbered `line_lvl` (1 raises it, 0 lowers it). A raise also clears `halted`.
- R10: `halt_enter` sets `halted` on the next edge, unless a raise event occurs in the same cycle, in which case `halted` is cleared.
- R11: A change of `softint`, `cur_pil`, `int_en`, `trap_lvl` or `active_tt` is reflected on `hard_req`/`sel_tt` one clock edge later. A line event is reflected two edges later: one edge to update the line vector and one to update the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_evt | input | 1 | Request-line update strobe |
| line_lvl | input | 4 | Request line addressed by the strobe |
| line_val | input | 1 | New value of that line (1 raise, 0 lower) |
| halt_enter | input | 1 | Core enters the halt state |
| softint | input | 16 | Software-interrupt word; bit 0 tick match, bit 15 system-tick match |
| cur_pil | input | 4 | Current processor interrupt level |
| int_en | input | 1 | Global interrupt enable |
| trap_lvl | input | 3 | Current trap level |
| active_tt | input | 9 | Trap type active at the current trap level |
| hard_req | output | 1 | Hard-interrupt request |
| sel_tt | output | 9 | Trap type of the selected interrupt, 0 when none |
| halted | output | 1 | Core halt state |

## Verification
Level, enable, trap and software-interrupt inputs reach `hard_req` and `sel_tt` after exactly one edge. A request-line event takes two edges, because the line vector is a register in front of the selector. `halted` follows its event after one edge. The bench drives inputs on the falling edge and holds them, then compares on a later falling edge: one for direct inputs and two for line events. A cycle-stepped reference model runs on each rising edge and is compared on every falling edge, so the latency is checked across a long pseudo-random stretch as well as in the directed sweeps.

// File: rtl/pil_sel_pkg.sv
// Package: shared defaults and the decision type of the interrupt level selector.
// Assumes a 16-level interrupt scheme with a 9-bit trap type field.
package pil_sel_pkg;

    localparam int unsigned    DEF_LEVELS      = 16;
    localparam int unsigned    DEF_TT_W        = 9;
    localparam int unsigned    DEF_TL_W        = 3;
    localparam int unsigned    DEF_TICK_POS    = 0;
    localparam int unsigned    DEF_STICK_POS   = 15;
    localparam int unsigned    DEF_TIMER_LEVEL = 14;
    localparam logic [8:0]     DEF_EXT_BASE    = 9'h040;

    // Action taken by the request controller on a clock edge
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_CLEAR = 2'd1,
        ACT_RAISE = 2'd2
    } pil_act_e;

endpackage

// File: rtl/pil_line_bank.sv
// Module: request-line vector and core halt flag.
// Each line is a flop written by a single-line event; a raise wakes the core.
// Assumes at most one line event per cycle.
module pil_line_bank #(
    parameter int unsigned NUM_LEVELS = 16,
    localparam int unsigned LVL_W     = $clog2(NUM_LEVELS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  line_evt,
    input  logic [LVL_W-1:0]      line_lvl,
    input  logic                  line_val,
    input  logic                  halt_enter,
    output logic [NUM_LEVELS-1:0] lines,
    output logic                  halted
);

    // One flop per request line, written only when addressed
    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n)
                lines[g] <= 1'b0;
            else if (line_evt && (line_lvl == LVL_W'(g)))
                lines[g] <= line_val;
        end
    end

    // Halt state: a raise wakes the core and wins over a halt strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            halted <= 1'b0;
        else if (line_evt && line_val)
            halted <= 1'b0;
        else if (halt_enter)
            halted <= 1'b1;
    end

    AST_WAKE_ON_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (line_evt && line_val) |=> !halted); // R9

    AST_LOWER_CLEARS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (line_evt && !line_val) |=> !lines[$past(line_lvl)]); // R9

    AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_enter && !(line_evt && line_val)) |=> halted); // R10

endmodule

// File: rtl/pil_pending.sv
// Module: builds the pending-level vector from request lines and the software word.
// The two timer-match bits are kept out of the OR and reported on TIMER_LEVEL instead.
// Purely combinational.
module pil_pending #(
    parameter int unsigned NUM_LEVELS  = 16,
    parameter int unsigned TICK_POS    = 0,
    parameter int unsigned STICK_POS   = 15,
    parameter int unsigned TIMER_LEVEL = 14
) (
    input  logic [NUM_LEVELS-1:0] lines,
    input  logic [NUM_LEVELS-1:0] softint,
    output logic [NUM_LEVELS-1:0] pend
);

    localparam logic [NUM_LEVELS-1:0] TIMER_MASK =
        (NUM_LEVELS'(1) << TICK_POS) | (NUM_LEVELS'(1) << STICK_POS);

    // Merge sources, then fold the timer matches onto their level
    always_comb begin
        pend = lines | (softint & ~TIMER_MASK);
        if (softint[TICK_POS] || softint[STICK_POS])
            pend[TIMER_LEVEL] = 1'b1;
    end

endmodule

// File: rtl/pil_prio_pick.sv
// Module: finds the highest pending level strictly above the current interrupt level.
// Combinational; clk/rst_n only time its assertions.
module pil_prio_pick #(
    parameter int unsigned NUM_LEVELS = 16,
    localparam int unsigned LVL_W     = $clog2(NUM_LEVELS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_LEVELS-1:0] pend,
    input  logic [LVL_W-1:0]      cur_pil,
    output logic                  found,
    output logic [LVL_W-1:0]      lvl
);

    logic [NUM_LEVELS-1:0] elig;

    // Eligibility per level: pending and above the current level
    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_elig
        assign elig[g] = pend[g] && (LVL_W'(g) > cur_pil);
    end

    // Priority encode, highest index wins
    always_comb begin
        found = 1'b0;
        lvl   = '0;
        for (int i = 0; i < NUM_LEVELS; i++) begin
            if (elig[i]) begin
                found = 1'b1;
                lvl   = LVL_W'(i);
            end
        end
    end

    AST_PICK_ABOVE_PIL: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (lvl > cur_pil)); // R5

    AST_PICK_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> pend[lvl]); // R4

endmodule

// File: rtl/pil_req_ctrl.sv
// Module: registered hard-request flag and selected trap type.
// Clears when nothing is pending, raises on a new unblocked candidate, else holds.
// Assumes the external base has its low LVL_W bits clear.
module pil_req_ctrl
    import pil_sel_pkg::*;
#(
    parameter int unsigned NUM_LEVELS = 16,
    parameter int unsigned TT_W       = 9,
    parameter int unsigned TL_W       = 3,
    parameter logic [TT_W-1:0] EXT_BASE = TT_W'(9'h040),
    localparam int unsigned LVL_W     = $clog2(NUM_LEVELS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pend_any,
    input  logic              found,
    input  logic [LVL_W-1:0]  lvl,
    input  logic              int_en,
    input  logic [TL_W-1:0]   trap_lvl,
    input  logic [TT_W-1:0]   active_tt,
    output logic              hard_req,
    output logic [TT_W-1:0]   sel_tt
);

    localparam logic [TT_W-1:0] LVL_MASK = TT_W'((1 << LVL_W) - 1);

    logic [TT_W-1:0] cand;
    logic            blocked;
    pil_act_e        act;

    // Candidate trap type and the nested-trap block condition
    always_comb begin
        cand    = EXT_BASE | {{(TT_W-LVL_W){1'b0}}, lvl};
        blocked = (trap_lvl != '0) && (active_tt > cand);
    end

    // Decide the action for this edge
    always_comb begin
        act = ACT_HOLD;
        if (!pend_any) begin
            if (hard_req)
                act = ACT_CLEAR;
        end else if (int_en && found && !blocked && (cand != sel_tt)) begin
            act = ACT_RAISE;
        end
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hard_req <= 1'b0;
            sel_tt   <= '0;
        end else begin
            case (act)
                ACT_CLEAR: begin
                    hard_req <= 1'b0;
                    sel_tt   <= '0;
                end
                ACT_RAISE: begin
                    hard_req <= 1'b1;
                    sel_tt   <= cand;
                end
                default: ;
            endcase
        end
    end

    AST_CLEAR_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_any && hard_req) |=> (!hard_req && (sel_tt == '0))); // R6

    AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_en && pend_any) |=> ($stable(hard_req) && $stable(sel_tt))); // R8

    AST_TRAP_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_any && found && (trap_lvl != '0) && (active_tt > cand))
            |=> ($stable(hard_req) && $stable(sel_tt))); // R7

    AST_TT_ON_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        hard_req |-> ((sel_tt & ~LVL_MASK) == EXT_BASE)); // R4

endmodule

// File: rtl/pil_select_top.sv
// Module: top of the interrupt level selector.
// Line bank -> pending merge -> priority pick -> registered request controller.
// Line events reach the outputs in two edges, other inputs in one.
module pil_select_top
    import pil_sel_pkg::*;
#(
    parameter int unsigned NUM_LEVELS  = DEF_LEVELS,
    parameter int unsigned TT_W        = DEF_TT_W,
    parameter int unsigned TL_W        = DEF_TL_W,
    parameter int unsigned TICK_POS    = DEF_TICK_POS,
    parameter int unsigned STICK_POS   = DEF_STICK_POS,
    parameter int unsigned TIMER_LEVEL = DEF_TIMER_LEVEL,
    parameter logic [TT_W-1:0] EXT_BASE = TT_W'(DEF_EXT_BASE),
    localparam int unsigned LVL_W      = $clog2(NUM_LEVELS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  line_evt,
    input  logic [LVL_W-1:0]      line_lvl,
    input  logic                  line_val,
    input  logic                  halt_enter,
    input  logic [NUM_LEVELS-1:0] softint,
    input  logic [LVL_W-1:0]      cur_pil,
    input  logic                  int_en,
    input  logic [TL_W-1:0]       trap_lvl,
    input  logic [TT_W-1:0]       active_tt,
    output logic                  hard_req,
    output logic [TT_W-1:0]       sel_tt,
    output logic                  halted
);

    logic [NUM_LEVELS-1:0] lines;
    logic [NUM_LEVELS-1:0] pend;
    logic                  pend_any;
    logic                  found;
    logic [LVL_W-1:0]      lvl;

    pil_line_bank #(.NUM_LEVELS(NUM_LEVELS)) u_lines (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_evt   (line_evt),
        .line_lvl   (line_lvl),
        .line_val   (line_val),
        .halt_enter (halt_enter),
        .lines      (lines),
        .halted     (halted)
    );

    pil_pending #(
        .NUM_LEVELS  (NUM_LEVELS),
        .TICK_POS    (TICK_POS),
        .STICK_POS   (STICK_POS),
        .TIMER_LEVEL (TIMER_LEVEL)
    ) u_pend (
        .lines   (lines),
        .softint (softint),
        .pend    (pend)
    );

    // Any level pending at all
    assign pend_any = |pend;

    pil_prio_pick #(.NUM_LEVELS(NUM_LEVELS)) u_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend    (pend),
        .cur_pil (cur_pil),
        .found   (found),
        .lvl     (lvl)
    );

    pil_req_ctrl #(
        .NUM_LEVELS (NUM_LEVELS),
        .TT_W       (TT_W),
        .TL_W       (TL_W),
        .EXT_BASE   (EXT_BASE)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_any  (pend_any),
        .found     (found),
        .lvl       (lvl),
        .int_en    (int_en),
        .trap_lvl  (trap_lvl),
        .active_tt (active_tt),
        .hard_req  (hard_req),
        .sel_tt    (sel_tt)
    );

endmodule

// File: tb/pil_select_top_tb.sv
// Bench: directed sweeps plus a cycle-stepped reference model compared every cycle.
module pil_select_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_evt = 1'b0;
    logic [3:0]  line_lvl = '0;
    logic        line_val = 1'b0;
    logic        halt_enter = 1'b0;
    logic [15:0] softint = '0;
    logic [3:0]  cur_pil = '0;
    logic        int_en = 1'b0;
    logic [2:0]  trap_lvl = '0;
    logic [8:0]  active_tt = '0;
    logic        hard_req;
    logic [8:0]  sel_tt;
    logic        halted;

    int          checks = 0;
    int          failures = 0;
    logic        chk_en = 1'b0;
    logic        done = 1'b0;
    string       tag = "R1";

    // Reference model state
    logic [15:0] m_lines = '0;
    logic        m_req = 1'b0;
    logic [8:0]  m_tt = '0;
    logic        m_halt = 1'b0;

    pil_select_top u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_evt   (line_evt),
        .line_lvl   (line_lvl),
        .line_val   (line_val),
        .halt_enter (halt_enter),
        .softint    (softint),
        .cur_pil    (cur_pil),
        .int_en     (int_en),
        .trap_lvl   (trap_lvl),
        .active_tt  (active_tt),
        .hard_req   (hard_req),
        .sel_tt     (sel_tt),
        .halted     (halted)
    );

    always #5 clk = ~clk;

    // Reference model, stepped on each rising edge from the held inputs
    always @(posedge clk) begin
        logic [15:0] p;
        logic        fnd;
        logic [8:0]  c;
        if (!rst_n) begin
            m_lines = '0; m_req = 1'b0; m_tt = '0; m_halt = 1'b0;
        end else begin
            p = m_lines | (softint & 16'h7FFE);
            if (softint[0] || softint[15]) p[14] = 1'b1;   // R3 fold
            if (p == 16'h0) begin
                if (m_req) begin m_req = 1'b0; m_tt = '0; end  // R6
            end else if (int_en) begin
                fnd = 1'b0; c = '0;
                for (int i = 15; i > 0; i--) begin
                    if (!fnd && p[i] && (i > int'(cur_pil))) begin
                        fnd = 1'b1; c = 9'h040 | 9'(i);
                    end
                end
                if (fnd && !((trap_lvl != 0) && (active_tt > c)) && (c != m_tt)) begin
                    m_tt = c; m_req = 1'b1;
                end
            end
            if (line_evt) m_lines[line_lvl] = line_val;
            if (line_evt && line_val) m_halt = 1'b0;
            else if (halt_enter) m_halt = 1'b1;
        end
    end

    task automatic check1(string t, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
        end
    endtask

    // Every cycle: outputs against the model (R11 latency)
    always @(negedge clk) begin
        if (chk_en && !done) begin
            check1(tag, "model sel_tt", int'(sel_tt), int'(m_tt));
            check1(tag, "model hard_req", int'(hard_req), int'(m_req));
            check1(tag, "model halted", int'(halted), int'(m_halt));
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic line_op(int lv, logic v);
        line_evt = 1'b1; line_lvl = 4'(lv); line_val = v;
        @(negedge clk);
        line_evt = 1'b0;
    endtask

    task automatic expect_out(string t, logic r, logic [8:0] tt);
        check1(t, "sel_tt", int'(sel_tt), int'(tt));
        check1(t, "hard_req", int'(hard_req), int'(r));
    endtask

    // Watchdog: a hung run is a failure and still reports
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        tick(3);
        rst_n = 1'b1;
        // R1: reset state
        tag = "R1";
        check1("R1", "hard_req", int'(hard_req), 0);
        check1("R1", "sel_tt", int'(sel_tt), 0);
        check1("R1", "halted", int'(halted), 0);
        chk_en = 1'b1;
        int_en = 1'b1;

        // R10: halt strobe sets halted after one edge
        tag = "R10";
        halt_enter = 1'b1; tick(1); halt_enter = 1'b0;
        check1("R10", "halted", int'(halted), 1);

        // R9: raise wakes in one edge, output in two
        tag = "R9";
        line_op(5, 1'b1);
        check1("R9", "halted after raise", int'(halted), 0);
        tick(1);
        expect_out("R9", 1'b1, 9'h045);
        line_op(5, 1'b0); tick(1);
        expect_out("R6", 1'b0, 9'h000);

        // R10: raise and halt in same cycle -> awake
        tag = "R10";
        halt_enter = 1'b1; line_evt = 1'b1; line_lvl = 4'd3; line_val = 1'b1;
        tick(1); halt_enter = 1'b0; line_evt = 1'b0;
        check1("R10", "raise wins", int'(halted), 0);
        line_op(3, 1'b0); tick(2);

        // R4/R5: sweep every pil against every single line
        for (int pl = 0; pl < 16; pl++) begin
            for (int lv = 1; lv < 16; lv++) begin
                tag = (lv > pl) ? "R4" : "R5";
                cur_pil = 4'(pl);
                line_op(lv, 1'b1); tick(1);
                if (lv > pl) expect_out("R4", 1'b1, 9'h040 | 9'(lv));
                else         expect_out("R5", 1'b0, 9'h000);
                line_op(lv, 1'b0); tick(1);
                expect_out("R6", 1'b0, 9'h000);
            end
        end
        cur_pil = '0;

        // R2/R3/R11: each softint bit alone, sampled one edge later
        for (int b = 0; b < 16; b++) begin
            tag = (b == 0 || b == 15) ? "R3" : "R2";
            softint = 16'(1) << b;
            tick(1);
            if (b == 0 || b == 15) expect_out("R3", 1'b1, 9'h04E);
            else                   expect_out("R11", 1'b1, 9'h040 | 9'(b));
            softint = '0; tick(1);
        end

        // R7: nested trap block over active trap types, candidate 0x49
        tag = "R7";
        trap_lvl = 3'd1;
        for (int a = 9'h040; a < 9'h050; a++) begin
            active_tt = 9'(a);
            softint = 16'h0200; tick(1);
            if (a > 9'h049) expect_out("R7", 1'b0, 9'h000);
            else            expect_out("R7", 1'b1, 9'h049);
            softint = '0; tick(1);
        end
        trap_lvl = 3'd0; active_tt = 9'h04F;
        softint = 16'h0200; tick(1);
        expect_out("R7", 1'b1, 9'h049);
        softint = '0; tick(1);
        active_tt = '0;

        // R8: disabled holds; clear still works while disabled
        tag = "R8";
        int_en = 1'b0; softint = 16'h0080; tick(1);
        expect_out("R8", 1'b0, 9'h000);
        int_en = 1'b1; tick(1);
        expect_out("R8", 1'b1, 9'h047);
        int_en = 1'b0; softint = 16'h1000; tick(2);
        expect_out("R8", 1'b1, 9'h047);
        softint = '0; tick(1);
        expect_out("R6", 1'b0, 9'h000);
        int_en = 1'b1;

        // R4/R11: mixed pseudo-random traffic against the model
        tag = "R4";
        seed = 32'h1234_5678;
        for (int n = 0; n < 6000; n++) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            line_evt   = (seed[31:29] == 3'b000);
            line_lvl   = seed[27:24];
            line_val   = seed[23];
            halt_enter = (seed[22:20] == 3'b000);
            if (seed[19:17] == 3'b000) softint = 16'(1) << seed[16:13];
            else if (seed[19:17] == 3'b001) softint = '0;
            cur_pil    = seed[12] ? 4'(seed[11:9]) : 4'(seed[11:8]);
            int_en     = (seed[7:5] != 3'b000);
            trap_lvl   = seed[4] ? 3'(seed[3:2]) : 3'd0;
            active_tt  = 9'h040 | 9'(seed[28:25]);
            tick(1);
        end
        line_evt = 1'b0; halt_enter = 1'b0;
        tick(2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule